// File: doc/BRIEF.md
# Bit-Slip Receive Word Aligner

This block re-frames a stream of parallel words arriving from a deserializer. The boundary between words is moved one bit at a time by an external controller. Each rising edge of a level-type slip request advances an internal shift amount by one, modulo the word width. Each output word is then built from the tail of the previous raw word and the head of the current raw word.

The block also compares the two most recent output words, taken as one double-width value, against an alignment pattern. When they match, it raises a one-cycle hit flag aligned with the newer word. A controller in the surrounding logic watches the output word and/or the hit flag and pulses the slip request until the framing is correct.

The pattern is a quasi-static input: it is read every cycle and has no handshake. The word width is 8 bits by default, so the pattern is 16 bits.

Top module: `bitslip_aligner`

## Requirements
- R1: While `rst_n` is sampled low, the shift amount returns to zero and the stored previous raw word is cleared. After reset, `aligned_word` reads 8'h00 and `pattern_hit` reads 0.
- R2: A slip edge is `slip_req` sampled high at a clock edge after it was sampled low at the edge before. A slip edge sampled at edge e advances the shift amount by exactly one. The word registered at edge e still uses the old framing. The word registered at edge e+1 uses the new framing.
- R3: Holding `slip_req` high for any number of cycles produces only one slip.
- R4: With shift amount k, the word registered at an edge is formed as follows. Its upper k bits are the low k bits of the raw word accepted at the previous edge. Its lower 8−k bits are the upper 8−k bits of the current `rx_word`. With k = 0, `aligned_word` equals the `rx_word` presented at the last edge.
- R5: With 8'hF0 applied continuously, four successive slips produce 8'h78, 8'h3C, 8'h1E and 8'h0F, in that order.
- R6: The shift amount wraps from 7 back to 0, so eight slips restore the unshifted framing.
- R7: `pattern_hit` is high in the cycle in which the current `aligned_word` (bits 15:8) together with the previous `aligned_word` (bits 7:0) equals `align_pattern`. For example, 8'h1E followed by 8'h0F matches 16'h0F1E.
- R8: `pattern_hit` is low in any cycle where that pair does not match, including the cycle right after a match.
- R9: A new value on `align_pattern` takes effect at the next clock edge, with no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_word | input | 8 | Raw word from the deserializer |
| slip_req | input | 1 | Level slip request; each rising edge slips one bit |
| align_pattern | input | 16 | Alignment pattern; bits 15:8 newer word, bits 7:0 older word |
| aligned_word | output | 8 | Re-framed registered word |
| pattern_hit | output | 1 | One-cycle flag: last two output words match the pattern |

## Verification
The bench targets the following corner cases, and each one exposes a specific kind of error:

- **Held-high slip request:** a level-triggered design would keep slipping and land several bits too far.
- **Wrap after eight slips:** a counter that saturates, or one that wraps to the wrong value, leaves the framing shifted instead of restoring it.
- **Byte order of the pattern compare:** swapping the newer and older words makes the hit miss the 8'h1E/8'h0F transition.
- **Cycle after a match:** a flag that is held instead of re-evaluated stays high for an extra cycle.
- **Reset in the middle of operation:** a shift amount that is not cleared shows up directly as a shifted word after reset.

// File: rtl/bsa_pkg.sv
// Shared constants for the bit-slip word aligner.
// Assumes: nothing; holds only default sizing.
package bsa_pkg;
    localparam int BSA_WORD_W = 8;
endpackage

// File: rtl/bsa_slip_ctrl.sv
// Slip controller: detects rising edges of the level slip request in the
// word clock domain and keeps the shift amount modulo WORD_W.
// Assumes: slip_req is already synchronous to clk.
module bsa_slip_ctrl #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slip_req,
    output logic [CNT_W-1:0] slip_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W - 1);

    logic slip_q;
    logic slip_rise;

    // Rising edge of the request against its previous sampled level.
    assign slip_rise = slip_req && !slip_q;

    // Remember the last sampled level of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) slip_q <= 1'b0;
        else        slip_q <= slip_req;
    end

    // Advance the shift amount on each edge, wrapping at the word width.
    always_ff @(posedge clk) begin
        if (!rst_n)         slip_cnt <= '0;
        else if (slip_rise) slip_cnt <= (slip_cnt == CNT_MAX) ? '0 : slip_cnt + CNT_W'(1);
    end

    // R2: one edge advances the amount by exactly one (with wrap).
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_req && !slip_q) |=>
        slip_cnt == (($past(slip_cnt) == CNT_MAX) ? '0 : $past(slip_cnt) + CNT_W'(1)));

    // R3: a held-high request leaves the amount unchanged.
    a_r3_held_no_slip: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_req && slip_q) |=> $stable(slip_cnt));

    // R1: reset clears the shift amount.
    a_r1_cnt_reset: assert property (@(posedge clk)
        !rst_n |=> slip_cnt == '0);
endmodule

// File: rtl/bsa_reframe.sv
// Re-framing shifter: holds the previous raw word and selects a WORD_W-bit
// window from {previous, current} according to the shift amount.
// Assumes: shift < WORD_W; output is combinational, registered downstream.
module bsa_reframe #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [CNT_W-1:0]  shift,
    output logic [WORD_W-1:0] framed
);
    logic [WORD_W-1:0]   raw_q;
    logic [2*WORD_W-1:0] joined;
    logic [WORD_W-1:0]   cand [WORD_W];

    // Keep the raw word accepted at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= rx_word;
    end

    assign joined = {raw_q, rx_word};

    // One candidate window per possible shift amount.
    for (genvar g = 0; g < WORD_W; g++) begin : g_win
        assign cand[g] = joined[g +: WORD_W];
    end

    assign framed = cand[shift];
endmodule

// File: rtl/bsa_match.sv
// Output stage: registers the framed word and flags when the newer and
// older registered words together equal the alignment pattern.
// Assumes: pattern is quasi-static and read every cycle without handshake.
module bsa_match #(
    parameter int WORD_W = 8,
    localparam int PAT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] framed,
    input  logic [PAT_W-1:0]  pattern,
    output logic [WORD_W-1:0] word_q,
    output logic              hit_q
);
    // Register the word and the compare of {new, old} against the pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            word_q <= framed;
            hit_q  <= ({framed, word_q} == pattern);
        end
    end

    // R7: a hit means the last two output words equal the pattern seen then.
    a_r7_hit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> {word_q, $past(word_q)} == $past(pattern));

    // R1: reset deasserts the flag.
    a_r1_hit_reset: assert property (@(posedge clk)
        !rst_n |=> !hit_q);
endmodule

// File: rtl/bitslip_aligner.sv
// Bit-slip receive word aligner top: slip controller, re-framing shifter
// and registered pattern compare.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module bitslip_aligner #(
    parameter int WORD_W = bsa_pkg::BSA_WORD_W,
    localparam int CNT_W = $clog2(WORD_W),
    localparam int PAT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              slip_req,
    input  logic [PAT_W-1:0]  align_pattern,
    output logic [WORD_W-1:0] aligned_word,
    output logic              pattern_hit
);
    logic [CNT_W-1:0]  slip_cnt;
    logic [WORD_W-1:0] framed;

    bsa_slip_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .slip_req(slip_req), .slip_cnt(slip_cnt)
    );

    bsa_reframe #(.WORD_W(WORD_W)) u_reframe (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .shift(slip_cnt), .framed(framed)
    );

    bsa_match #(.WORD_W(WORD_W)) u_match (
        .clk(clk), .rst_n(rst_n), .framed(framed), .pattern(align_pattern),
        .word_q(aligned_word), .hit_q(pattern_hit)
    );
endmodule

// File: tb/bitslip_aligner_bench.sv
module bitslip_aligner_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rx_word;
    logic        slip_req;
    logic [15:0] align_pattern;
    logic [7:0]  aligned_word;
    logic        pattern_hit;
    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    bitslip_aligner u_bitslip_aligner (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .slip_req(slip_req),
        .align_pattern(align_pattern), .aligned_word(aligned_word),
        .pattern_hit(pattern_hit)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word at the falling edge; return after the next rising edge.
    task automatic step(input logic [7:0] w, input logic s);
        @(negedge clk);
        rx_word  = w;
        slip_req = s;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; slip_req = 1'b0; rx_word = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One complete slip: a rising edge, then the request goes low again.
    task automatic pulse(input logic [7:0] w);
        step(w, 1'b1);
        step(w, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 word after reset", {8'h0, aligned_word}, 16'h0000);
        check("R1 hit after reset", {15'h0, pattern_hit}, 16'h0000);
    endtask

    task automatic t_passthrough();
        do_reset();
        step(8'hC3, 0); check("R4 k=0 word", {8'h0, aligned_word}, 16'h00C3);
        step(8'h17, 0); check("R4 k=0 word", {8'h0, aligned_word}, 16'h0017);
        // three slips, then prev=A5 cur=3C gives {101,00111}=A7
        pulse(8'h00); pulse(8'h00); pulse(8'h00);
        step(8'hA5, 0);
        step(8'h3C, 0); check("R4 k=3 word", {8'h0, aligned_word}, 16'h00A7);
    endtask

    task automatic t_f0_sequence();
        logic [7:0] exp_seq [4] = '{8'h78, 8'h3C, 8'h1E, 8'h0F};
        do_reset();
        align_pattern = 16'h0F1E;
        step(8'hF0, 0); step(8'hF0, 0);
        check("R8 no hit before slips", {15'h0, pattern_hit}, 16'h0000);
        for (int i = 0; i < 4; i++) begin
            step(8'hF0, 1);
            step(8'hF0, 0);
            check("R5 slip sequence word", {8'h0, aligned_word}, {8'h0, exp_seq[i]});
            check("R7 hit on 1E then 0F", {15'h0, pattern_hit}, (i == 3) ? 16'h1 : 16'h0);
            step(8'hF0, 0);
            check("R8 hit low after", {15'h0, pattern_hit}, 16'h0000);
        end
    endtask

    task automatic t_held_high();
        do_reset();
        step(8'h00, 1);
        for (int i = 0; i < 5; i++) step(8'h00, 1);
        step(8'h00, 0);
        step(8'hFF, 0);
        check("R3 held request slips once", {8'h0, aligned_word}, 16'h007F);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 8; i++) pulse(8'h00);
        step(8'h12, 0);
        step(8'h34, 0);
        check("R6 eight slips unshifted", {8'h0, aligned_word}, 16'h0034);
        pulse(8'h00);
        step(8'h12, 0);
        step(8'h34, 0);
        check("R6 ninth slip k=1", {8'h0, aligned_word}, 16'h001A);
    endtask

    task automatic t_pattern_change();
        do_reset();
        align_pattern = 16'h5AA5;
        step(8'hA5, 0);
        step(8'h5A, 0);
        check("R9 hit with new pattern", {15'h0, pattern_hit}, 16'h0001);
        align_pattern = 16'h1234;
        step(8'hA5, 0);
        step(8'h5A, 0);
        check("R9 no hit after pattern change", {15'h0, pattern_hit}, 16'h0000);
    endtask

    task automatic t_mid_reset();
        pulse(8'h00); pulse(8'h00);
        do_reset();
        check("R1 word cleared mid-run", {8'h0, aligned_word}, 16'h0000);
        step(8'h00, 0);
        step(8'hFF, 0);
        check("R1 shift cleared mid-run", {8'h0, aligned_word}, 16'h00FF);
    endtask

    initial begin
        #2000000;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; slip_req = 1'b0; rx_word = 8'h00; align_pattern = 16'h0F1E;
        t_reset();
        t_passthrough();
        t_f0_sequence();
        t_held_high();
        t_wrap();
        t_pattern_change();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule